// File: doc/BRIEF.md
# Conditional Branch Resolver with Restricted Link Write

This block settles the outcome of one conditional branch. It takes the condition bit, which comes from an upstream evaluator (a single flag bit or a reduction over many elements), and the four branch-option bits. From these it works out three things: whether the branch is taken, the next instruction address, and the counter and link values to write back. The counter can be reduced by one or by a vector length. A 32-bit mode limits the counter zero test to the low half of the counter.

One instruction is presented per `valid_i` strobe, with all operands on the ports at that time. The combinational result is captured in the output register on that clock edge, so it appears one cycle after the strobe. `out_valid_o` pulses in that cycle. Nothing carries over between instructions. The two write enables are only ever high in a cycle where `out_valid_o` is high. When no instruction is presented, the address, counter and link outputs keep their previous values.

Top module: `branch_resolve`

## Requirements
- R1: The condition check passes when `bo_i[0]` (condition ignore) is 1, or when `cond_i` equals `bo_i[1]` (wanted condition sense).
- R2: When `bo_i[2]` (counter skip) is 0 and `cnt_vl_mode_i` is 0, the counter output is `cnt_i - 1` and `cnt_we_o` is 1.
- R3: When `bo_i[2]` is 0 and `cnt_vl_mode_i` is 1, the counter output is `cnt_i - vl_i`. The subtraction wraps modulo 2^64, and the zero test uses the wrapped value.
- R4: When `bo_i[2]` is 1, the counter is not written (`cnt_we_o` = 0) and the counter check passes.
- R5: With `bo_i[2]` = 0, the counter check passes when (tested bits of the new counter non-zero) XOR `bo_i[3]` is 1. The tested bits are all 64 bits when `mode64_i` = 1 and the low 32 bits otherwise.
- R6: The branch is taken (`taken_o` = 1) only when both the counter check and the condition check pass.
- R7: The target of a taken branch is the sign-extended value `{bd_i, 2'b00}`. It is used as an absolute address when `aa_i` = 1 and is added to `cia_i` when `aa_i` = 0.
- R8: When the branch is not taken, `nia_o` equals `cia_i + 4`.
- R9: When `lk_i` = 1, `lr_o` = `cia_i + 4`. `lr_we_o` is 1 when `lru_i` = 0, or when `lru_i` = 1 and the branch is taken. When `lk_i` = 0, `lr_we_o` is 0.
- R10: Results appear in the cycle after `valid_i` together with a one-cycle `out_valid_o`. In cycles without a result, both write enables are 0 and `nia_o`, `cnt_o`, `lr_o` hold their values.
- R11: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction operands present |
| cia_i | input | 64 | Address of the branch instruction |
| bd_i | input | 14 | Word displacement, signed |
| aa_i | input | 1 | Absolute addressing |
| lk_i | input | 1 | Link request |
| bo_i | input | 4 | [0] ignore condition, [1] condition sense, [2] skip counter, [3] counter sense |
| mode64_i | input | 1 | 1: 64-bit counter test, 0: low 32 bits |
| cnt_i | input | 64 | Current counter value |
| lru_i | input | 1 | Restrict link write to taken branches |
| cnt_vl_mode_i | input | 1 | Reduce counter by vector length |
| vl_i | input | 7 | Vector length (already truncated) |
| cond_i | input | 1 | Condition bit under test |
| out_valid_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Branch taken |
| nia_o | output | 64 | Next instruction address |
| cnt_o | output | 64 | New counter value |
| cnt_we_o | output | 1 | Counter write enable |
| lr_o | output | 64 | New link value |
| lr_we_o | output | 1 | Link write enable |

## Verification
The bench targets the counter reaching exactly zero after the decrement, so a design that tests the old counter value would take the wrong path. It uses a vector length larger than the counter, where a saturating subtract or a test before wrapping would give the wrong result. It sets a counter whose low half is zero but whose high half is not, to catch a design that ignores the 32-bit mode. It also drives negative displacements in both addressing modes, and not-taken branches with `lru_i` both set and clear. A wrong sign extension, or a link write that ignores the restrict flag, shows up as an address or write-enable mismatch.

// File: rtl/br_pkg.sv
package br_pkg;
  parameter int unsigned XLEN = 64;

  typedef struct packed {
    logic            taken;
    logic [XLEN-1:0] nia;
    logic [XLEN-1:0] cnt;
    logic            cnt_we;
    logic [XLEN-1:0] lr;
    logic            lr_we;
  } br_res_t;
endpackage

// File: rtl/br_cnt_unit.sv
module br_cnt_unit #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VL_W = 7
) (
  input  logic [XLEN-1:0] cnt_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            vl_mode_i,
  input  logic            mode64_i,
  input  logic            skip_i,
  input  logic            sense_i,
  output logic [XLEN-1:0] cnt_o,
  output logic            cnt_we_o,
  output logic            cnt_ok_o
);
  localparam int unsigned HALF = XLEN / 2;

  logic [XLEN-1:0] step;
  logic            nz_lo, nz_hi, nz;

  always_comb begin
    step = vl_mode_i ? XLEN'(vl_i) : XLEN'(1);
    cnt_o = skip_i ? cnt_i : cnt_i - step;
  end

  // zero test on post-decrement value
  assign nz_lo    = |cnt_o[HALF-1:0];
  assign nz_hi    = |cnt_o[XLEN-1:HALF];
  assign nz       = nz_lo | (mode64_i & nz_hi);
  assign cnt_we_o = ~skip_i;
  assign cnt_ok_o = skip_i | (nz ^ sense_i);
endmodule

// File: rtl/br_target_unit.sv
module br_target_unit #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned BD_W = 14
) (
  input  logic [XLEN-1:0] cia_i,
  input  logic [BD_W-1:0] bd_i,
  input  logic            aa_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] seq_o
);
  localparam int unsigned OFF_W = BD_W + 2;

  logic [OFF_W-1:0] off_raw;
  logic [XLEN-1:0]  off_ext;

  assign off_raw  = {bd_i, 2'b00};
  assign off_ext  = {{(XLEN-OFF_W){off_raw[OFF_W-1]}}, off_raw};
  assign target_o = aa_i ? off_ext : cia_i + off_ext;
  assign seq_o    = cia_i + XLEN'(4);
endmodule

// File: rtl/br_link_unit.sv
module br_link_unit #(
  parameter int unsigned XLEN = 64
) (
  input  logic            lk_i,
  input  logic            lru_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] seq_i,
  output logic [XLEN-1:0] lr_o,
  output logic            lr_we_o
);
  assign lr_o    = seq_i;
  assign lr_we_o = lk_i & (taken_i | ~lru_i);
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import br_pkg::*;
#(
  parameter int unsigned BD_W = 14,
  parameter int unsigned VL_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [XLEN-1:0] cia_i,
  input  logic [BD_W-1:0] bd_i,
  input  logic            aa_i,
  input  logic            lk_i,
  input  logic [3:0]      bo_i,
  input  logic            mode64_i,
  input  logic [XLEN-1:0] cnt_i,
  input  logic            lru_i,
  input  logic            cnt_vl_mode_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            cond_i,
  output logic            out_valid_o,
  output logic            taken_o,
  output logic [XLEN-1:0] nia_o,
  output logic [XLEN-1:0] cnt_o,
  output logic            cnt_we_o,
  output logic [XLEN-1:0] lr_o,
  output logic            lr_we_o
);
  logic [XLEN-1:0] cnt_nx, target, seq, lr_nx;
  logic            cnt_we_nx, cnt_ok, cond_ok, taken, lr_we_nx;
  br_res_t         res_d, res_q;
  logic            vld_q;

  br_cnt_unit #(.XLEN(XLEN), .VL_W(VL_W)) u_cnt (
    .cnt_i     (cnt_i),
    .vl_i      (vl_i),
    .vl_mode_i (cnt_vl_mode_i),
    .mode64_i  (mode64_i),
    .skip_i    (bo_i[2]),
    .sense_i   (bo_i[3]),
    .cnt_o     (cnt_nx),
    .cnt_we_o  (cnt_we_nx),
    .cnt_ok_o  (cnt_ok)
  );

  br_target_unit #(.XLEN(XLEN), .BD_W(BD_W)) u_tgt (
    .cia_i    (cia_i),
    .bd_i     (bd_i),
    .aa_i     (aa_i),
    .target_o (target),
    .seq_o    (seq)
  );

  assign cond_ok = bo_i[0] | ~(cond_i ^ bo_i[1]);
  assign taken   = cond_ok & cnt_ok;

  br_link_unit #(.XLEN(XLEN)) u_lnk (
    .lk_i    (lk_i),
    .lru_i   (lru_i),
    .taken_i (taken),
    .seq_i   (seq),
    .lr_o    (lr_nx),
    .lr_we_o (lr_we_nx)
  );

  always_comb begin
    res_d.taken  = taken;
    res_d.nia    = taken ? target : seq;
    res_d.cnt    = cnt_nx;
    res_d.cnt_we = cnt_we_nx;
    res_d.lr     = lr_nx;
    res_d.lr_we  = lr_we_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        res_q <= res_d;
      end else begin
        // hold values, drop strobes
        res_q.cnt_we <= 1'b0;
        res_q.lr_we  <= 1'b0;
      end
    end
  end

  assign out_valid_o = vld_q;
  assign taken_o     = res_q.taken;
  assign nia_o       = res_q.nia;
  assign cnt_o       = res_q.cnt;
  assign cnt_we_o    = res_q.cnt_we;
  assign lr_o        = res_q.lr;
  assign lr_we_o     = res_q.lr_we;
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk
  import br_pkg::*;
#(
  parameter int unsigned BD_W = 14,
  parameter int unsigned VL_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [XLEN-1:0] cia_i,
  input logic            lk_i,
  input logic [3:0]      bo_i,
  input logic            lru_i,
  input logic            out_valid_o,
  input logic            taken_o,
  input logic [XLEN-1:0] nia_o,
  input logic            cnt_we_o,
  input logic [XLEN-1:0] lr_o,
  input logic            lr_we_o
);
  assert_we_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (!cnt_we_o && !lr_we_o));

  assert_hold_nia_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(nia_o));

  assert_cnt_skip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bo_i[2]) |=> !cnt_we_o);

  assert_seq_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (taken_o || nia_o == $past(cia_i) + 64'd4));

  assert_link_rule_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (lr_we_o == ($past(lk_i) && (!$past(lru_i) || taken_o))));

  assert_link_val_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_we_o |-> (lr_o == $past(cia_i) + 64'd4));

  assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> out_valid_o);
endmodule

bind branch_resolve branch_resolve_chk #(.BD_W(BD_W), .VL_W(VL_W)) u_chk (.*);

// File: tb/branch_resolve_bench.sv
module branch_resolve_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BD_W = 14;
  localparam int VL_W = 7;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [63:0]     cia_i = '0;
  logic [BD_W-1:0] bd_i = '0;
  logic            aa_i = 1'b0, lk_i = 1'b0;
  logic [3:0]      bo_i = '0;
  logic            mode64_i = 1'b0;
  logic [63:0]     cnt_i = '0;
  logic            lru_i = 1'b0, cnt_vl_mode_i = 1'b0;
  logic [VL_W-1:0] vl_i = '0;
  logic            cond_i = 1'b0;
  logic            out_valid_o, taken_o, cnt_we_o, lr_we_o;
  logic [63:0]     nia_o, cnt_o, lr_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  branch_resolve #(.BD_W(BD_W), .VL_W(VL_W)) u_branch_resolve (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural reference
  logic        e_taken, e_cwe, e_lwe;
  logic [63:0] e_nia, e_cnt, e_lr;

  task automatic model();
    longint unsigned c, t, off;
    bit cnt_ok, cond_ok, nz;
    c = cnt_i;
    if (!bo_i[2]) c = c - (cnt_vl_mode_i ? longint'(vl_i) : 64'd1);
    nz = mode64_i ? (c != 0) : (c[31:0] != 0);
    cnt_ok = bo_i[2] || (nz != bo_i[3]);
    cond_ok = bo_i[0] || (cond_i == bo_i[1]);
    off = longint'(signed'(bd_i)) * 4;
    t = aa_i ? off : cia_i + off;
    e_taken = cnt_ok && cond_ok;
    e_nia = e_taken ? t : cia_i + 4;
    e_cnt = c;
    e_cwe = !bo_i[2];
    e_lr = cia_i + 4;
    e_lwe = lk_i && (e_taken || !lru_i);
  endtask

  task automatic run(string tag);
    model();
    valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({tag, " R10 out_valid"}, 64'(out_valid_o), 64'd1);
    chk({tag, " R6 taken"}, 64'(taken_o), 64'(e_taken));
    chk({tag, " R7 R8 nia"}, nia_o, e_nia);
    chk({tag, " R2 R3 R4 cnt_we"}, 64'(cnt_we_o), 64'(e_cwe));
    if (e_cwe) chk({tag, " R2 R3 cnt"}, cnt_o, e_cnt);
    chk({tag, " R9 lr_we"}, 64'(lr_we_o), 64'(e_lwe));
    if (e_lwe) chk({tag, " R9 lr"}, lr_o, e_lr);
  endtask

  task automatic idle_check();
    logic [63:0] n0;
    n0 = nia_o;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R10 idle valid", 64'(out_valid_o), 64'd0);
    chk("R10 idle cnt_we", 64'(cnt_we_o), 64'd0);
    chk("R10 idle lr_we", 64'(lr_we_o), 64'd0);
    chk("R10 idle nia hold", nia_o, n0);
  endtask

  task automatic set(logic [63:0] cia, logic [BD_W-1:0] bd, logic aa, logic lk,
                     logic [3:0] bo, logic m64, logic [63:0] cnt, logic lru,
                     logic vm, logic [VL_W-1:0] vl, logic cond);
    cia_i = cia; bd_i = bd; aa_i = aa; lk_i = lk; bo_i = bo; mode64_i = m64;
    cnt_i = cnt; lru_i = lru; cnt_vl_mode_i = vm; vl_i = vl; cond_i = cond;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 valid", 64'(out_valid_o), 0);
    chk("R11 nia", nia_o, 0);
    chk("R11 cnt", cnt_o, 0);
    chk("R11 lr", lr_o, 0);
    chk("R11 we", 64'({cnt_we_o, lr_we_o, taken_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 post-release nia", nia_o, 0);

    // R1 condition sense, counter skipped (R4)
    set(64'h1000, 14'h10, 0, 0, 4'b0110, 1, 64'd9, 0, 0, 0, 1); run("R1 cond match");
    set(64'h1000, 14'h10, 0, 0, 4'b0110, 1, 64'd9, 0, 0, 0, 0); run("R1 cond miss");
    set(64'h1000, 14'h10, 0, 0, 4'b0101, 1, 64'd9, 0, 0, 0, 0); run("R1 cond ignore");
    // R2 counter hits zero, branch-if-nonzero -> not taken
    set(64'h2000, 14'h3, 0, 1, 4'b0001, 1, 64'd1, 1, 0, 0, 0); run("R2 cnt to zero");
    // R9 not taken with lru clear still links
    set(64'h2000, 14'h3, 0, 1, 4'b0001, 1, 64'd1, 0, 0, 0, 0); run("R9 lru clear");
    // R5 branch-if-zero sense
    set(64'h2000, 14'h3, 0, 1, 4'b1001, 1, 64'd1, 1, 0, 0, 0); run("R5 sense zero");
    // R3 VL larger than counter wraps
    set(64'h3000, 14'h3ff0, 0, 0, 4'b0001, 1, 64'd3, 0, 1, 7'd5, 0); run("R3 wrap");
    set(64'h3000, 14'h3ff0, 0, 0, 4'b0001, 1, 64'd40, 0, 1, 7'd40, 0); run("R3 vl exact");
    // R5 32-bit mode: low half zero
    set(64'h4000, 14'h20, 0, 0, 4'b0001, 0, 64'h1_0000_0001, 0, 0, 0, 0); run("R5 mode32");
    set(64'h4000, 14'h20, 0, 0, 4'b0001, 1, 64'h1_0000_0001, 0, 0, 0, 0); run("R5 mode64");
    // R7 absolute negative and relative negative
    set(64'h8000, 14'h2000, 1, 1, 4'b0101, 1, 0, 1, 0, 0, 0); run("R7 abs neg");
    set(64'h8000, 14'h3fff, 0, 1, 4'b0101, 1, 0, 1, 0, 0, 0); run("R7 rel neg");
    idle_check();
    idle_check();

    for (int i = 0; i < 400; i++) begin
      set({$urandom, $urandom}, 14'($urandom), 1'($urandom), 1'($urandom),
          4'($urandom), 1'($urandom),
          ($urandom % 4 == 0) ? 64'($urandom % 8) : {$urandom, $urandom},
          1'($urandom), 1'($urandom), 7'($urandom), 1'($urandom));
      run("R6 random");
      if (i % 16 == 0) idle_check();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule